// File: doc/BRIEF.md
# Translation Lookaside Lookup with Privilege-Ring Check

This block translates a virtual address through a small set-associative translation buffer in which every way is searched at the same time. Each way keeps a few entries, and each entry holds a virtual page base, a physical page base, an 8-bit address-space identifier and a 4-bit attribute code. Each way has its own fixed page size. The address bits just above a way's page offset choose the entry to compare in that way. An entry is usable only if its identifier is non-zero and appears in one of the four byte lanes of a 32-bit ring-identifier word. The lane that matches gives the privilege ring that owns the page.

A lookup supplies the address, an access kind (load, store or instruction fetch), the current privilege index and the ring-identifier word. One clock later the block presents a registered result. On success this is the physical address, the effective read/write/execute rights, the cache mode and the owning ring. On failure it is a cause code that tells apart a miss, a multiple hit, a privilege violation and a prohibited access, with separate codes for the instruction side and the data side. Entries are loaded through a write port that names the way, the index and the entry contents. The surrounding logic normally loads the ring word with 0x04030201 when it comes out of reset.

Top module: `tlbx_lookup`

## Requirements
- R1: Byte lane i of `ring_ids` (bits 8i+7:8i) belongs to ring i. When several lanes hold an entry's identifier, the lowest lane sets the ring. An identifier that is in no lane makes the entry unusable.
- R2: In way w, with page shift S = 12 + 2w at default parameters, the entry picked by address bits [S+1:S] hits only when three things hold: its stored page base equals the address in bits 31:S, its identifier is non-zero, and the identifier resolves to a ring under R1.
- R3: If no way hits, the result fails with the miss cause: 16 for a fetch, 24 for a load or store. If two or more ways hit, it fails with the multi-hit cause: 17 for a fetch, 25 for a load or store.
- R4: With exactly one hit, a ring numerically below `lk_priv` fails with the privilege cause: 18 for a fetch, 26 for a load or store. This check comes before the rights check.
- R5: An attribute below 12 always grants read. Bit 0 grants execute and bit 1 grants write. Bits 3:2 give the cache mode: 0 gives bypass, 1 gives write-back, 2 gives write-through. On `res_cache` these come out as 1 (bypass), 2 (write-back) and 3 (write-through).
- R6: Attribute 13 grants read and write with cache mode isolate, shown as 4 on `res_cache`. Attributes 12, 14 and 15 grant nothing, and their cache mode is none (0).
- R7: Access kind is encoded as 0 load, 1 store, 2 fetch. Data accesses lose execute rights, and fetches lose read and write rights. An access whose right is missing fails with cause 28 for a load, 29 for a store and 20 for a fetch.
- R8: On success, `res_paddr` takes bits 31:S from the entry's physical page base and bits S-1:0 from the virtual address. The low bits stored in the entry are ignored in both the compare and the translation.
- R9: `res_valid` is high exactly in the cycle after each cycle with `lk_valid` high. Success shows `res_ok`=1 with cause 0. A failure shows `res_ok`=0 with the physical address, rights, cache mode and ring all zero. After reset every entry is invalid, so every lookup misses.
- R10: An entry written on one clock edge takes part in lookups from the next cycle on. Writing identifier 0 removes the entry from use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one entry this cycle |
| wr_way | input | 2 | Way to write |
| wr_idx | input | 2 | Entry index within the way |
| wr_vpage | input | 32 | Virtual page base (bits below the page shift ignored) |
| wr_ppage | input | 32 | Physical page base (bits below the page shift ignored) |
| wr_asid | input | 8 | Address-space identifier, 0 = invalid |
| wr_attr | input | 4 | Attribute code |
| lk_valid | input | 1 | Start a lookup this cycle |
| lk_vaddr | input | 32 | Virtual address |
| lk_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| lk_priv | input | 2 | Current privilege index |
| ring_ids | input | 32 | Four identifier bytes, byte i for ring i |
| res_valid | output | 1 | Result present |
| res_ok | output | 1 | Translation succeeded |
| res_cause | output | 5 | Fault cause, 0 on success |
| res_paddr | output | 32 | Physical address |
| res_read | output | 1 | Effective read right |
| res_write | output | 1 | Effective write right |
| res_exec | output | 1 | Effective execute right |
| res_cache | output | 3 | Cache mode: 0 none, 1 bypass, 2 write-back, 3 write-through, 4 isolate |
| res_ring | output | 2 | Ring owning the hit page |

## Verification
A stored entry that is corrupt or stale shows up in the very next registered result. A bad identifier or page base turns an expected success into a miss or a multi-hit cause. A bad physical base changes the bits of `res_paddr` above the page offset. A bad attribute changes the rights, the cache mode or the prohibited cause. A wrong ring resolution shows up on `res_ring`, or as a privilege cause appearing or missing when `lk_priv` is close to the ring. Every scenario therefore writes an entry and reads it back through a lookup in the following cycles, so a fault becomes visible within two clocks of its cause.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  localparam int RING_CNT = 4;

  typedef enum logic [1:0] {ACC_LOAD = 2'd0, ACC_STORE = 2'd1, ACC_FETCH = 2'd2} acc_kind_e;
  typedef enum logic [2:0] {
    CM_NONE = 3'd0, CM_BYPASS = 3'd1, CM_WBACK = 3'd2, CM_WTHRU = 3'd3, CM_ISOLATE = 3'd4
  } cache_mode_e;

  typedef struct packed {
    logic        rd;
    logic        wr;
    logic        ex;
    cache_mode_e cm;
  } perm_t;

  localparam logic [4:0] C_I_MISS   = 5'd16;
  localparam logic [4:0] C_I_MULTI  = 5'd17;
  localparam logic [4:0] C_I_PRIV   = 5'd18;
  localparam logic [4:0] C_I_DENY   = 5'd20;
  localparam logic [4:0] C_D_MISS   = 5'd24;
  localparam logic [4:0] C_D_MULTI  = 5'd25;
  localparam logic [4:0] C_D_PRIV   = 5'd26;
  localparam logic [4:0] C_LD_DENY  = 5'd28;
  localparam logic [4:0] C_ST_DENY  = 5'd29;
endpackage

// File: rtl/tlbx_ring_map.sv
module tlbx_ring_map #(
  parameter int N_RINGS = 4,
  parameter int ID_W    = 8,
  parameter int RING_W  = $clog2(N_RINGS)
) (
  input  logic [N_RINGS*ID_W-1:0] ring_ids,
  input  logic [ID_W-1:0]         asid,
  output logic                    found,
  output logic [RING_W-1:0]       ring
);
  // Scan from the top lane down so the lowest matching lane is the last to assign.
  always_comb begin
    found = 1'b0;
    ring  = '0;
    for (int i = N_RINGS - 1; i >= 0; i--) begin
      if (ring_ids[i*ID_W +: ID_W] == asid) begin
        found = 1'b1;
        ring  = RING_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlbx_attr_decode.sv
module tlbx_attr_decode
  import tlbx_pkg::*;
(
  input  logic [3:0] attr,
  output perm_t      perm
);
  always_comb begin
    perm = '0;
    if (attr < 4'd12) begin
      perm.rd = 1'b1;
      perm.ex = attr[0];
      perm.wr = attr[1];
      case (attr[3:2])
        2'd0:    perm.cm = CM_BYPASS;
        2'd1:    perm.cm = CM_WBACK;
        default: perm.cm = CM_WTHRU;
      endcase
    end else if (attr == 4'd13) begin
      perm.rd = 1'b1;
      perm.wr = 1'b1;
      perm.cm = CM_ISOLATE;
    end
  end
endmodule

// File: rtl/tlbx_way.sv
module tlbx_way #(
  parameter int VA_W     = 32,
  parameter int IDX_W    = 2,
  parameter int ID_W     = 8,
  parameter int PG_SHIFT = 12,
  parameter int N_RINGS  = 4,
  parameter int RING_W   = $clog2(N_RINGS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [VA_W-1:0]         wr_vpage,
  input  logic [VA_W-1:0]         wr_ppage,
  input  logic [ID_W-1:0]         wr_asid,
  input  logic [3:0]              wr_attr,
  input  logic [VA_W-1:0]         lk_vaddr,
  input  logic [N_RINGS*ID_W-1:0] ring_ids,
  output logic                    hit,
  output logic [RING_W-1:0]       ring,
  output logic [VA_W-1:0]         paddr,
  output logic [3:0]              attr
);
  localparam int ENT_N = 1 << IDX_W;
  localparam logic [VA_W-1:0] OFS_MASK = {VA_W{1'b1}} >> (VA_W - PG_SHIFT);

  logic [VA_W-1:0] vpg_q  [ENT_N];
  logic [VA_W-1:0] ppg_q  [ENT_N];
  logic [ID_W-1:0] asid_q [ENT_N];
  logic [3:0]      attr_q [ENT_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENT_N; e++) begin
        vpg_q[e]  <= '0;
        ppg_q[e]  <= '0;
        asid_q[e] <= '0;
        attr_q[e] <= '0;
      end
    end else if (wr_en) begin
      vpg_q[wr_idx]  <= wr_vpage & ~OFS_MASK;
      ppg_q[wr_idx]  <= wr_ppage & ~OFS_MASK;
      asid_q[wr_idx] <= wr_asid;
      attr_q[wr_idx] <= wr_attr;
    end
  end

  logic [IDX_W-1:0] sel;
  logic             id_known;
  logic             page_eq;

  assign sel     = lk_vaddr[PG_SHIFT +: IDX_W];
  assign page_eq = (vpg_q[sel] == (lk_vaddr & ~OFS_MASK));

  tlbx_ring_map #(.N_RINGS(N_RINGS), .ID_W(ID_W), .RING_W(RING_W)) u_ring (
    .ring_ids (ring_ids),
    .asid     (asid_q[sel]),
    .found    (id_known),
    .ring     (ring)
  );

  assign hit   = page_eq && (asid_q[sel] != '0) && id_known;
  assign paddr = ppg_q[sel] | (lk_vaddr & OFS_MASK);
  assign attr  = attr_q[sel];

  // R2: an invalid (zero) identifier never produces a hit
  p_zero_id_no_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (asid_q[sel] == '0) |-> !hit);
endmodule

// File: rtl/tlbx_lookup.sv
module tlbx_lookup
  import tlbx_pkg::*;
#(
  parameter int VA_W        = 32,
  parameter int N_WAYS      = 4,
  parameter int IDX_W       = 2,
  parameter int ID_W        = 8,
  parameter int BASE_SHIFT  = 12,
  parameter int SHIFT_STEP  = 2,
  parameter int WAY_W       = $clog2(N_WAYS),
  parameter int RING_W      = $clog2(RING_CNT)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [WAY_W-1:0]         wr_way,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [VA_W-1:0]          wr_vpage,
  input  logic [VA_W-1:0]          wr_ppage,
  input  logic [ID_W-1:0]          wr_asid,
  input  logic [3:0]               wr_attr,
  input  logic                     lk_valid,
  input  logic [VA_W-1:0]          lk_vaddr,
  input  logic [1:0]               lk_kind,
  input  logic [RING_W-1:0]        lk_priv,
  input  logic [RING_CNT*ID_W-1:0] ring_ids,
  output logic                     res_valid,
  output logic                     res_ok,
  output logic [4:0]               res_cause,
  output logic [VA_W-1:0]          res_paddr,
  output logic                     res_read,
  output logic                     res_write,
  output logic                     res_exec,
  output logic [2:0]               res_cache,
  output logic [RING_W-1:0]        res_ring
);
  localparam int CNT_W = $clog2(N_WAYS + 1);

  logic [N_WAYS-1:0] hit_vec;
  logic [RING_W-1:0] way_ring  [N_WAYS];
  logic [VA_W-1:0]   way_paddr [N_WAYS];
  logic [3:0]        way_attr  [N_WAYS];

  for (genvar w = 0; w < N_WAYS; w++) begin : g_way
    tlbx_way #(
      .VA_W(VA_W), .IDX_W(IDX_W), .ID_W(ID_W),
      .PG_SHIFT(BASE_SHIFT + w * SHIFT_STEP), .N_RINGS(RING_CNT), .RING_W(RING_W)
    ) u_way (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en && (wr_way == WAY_W'(w))),
      .wr_idx   (wr_idx),
      .wr_vpage (wr_vpage),
      .wr_ppage (wr_ppage),
      .wr_asid  (wr_asid),
      .wr_attr  (wr_attr),
      .lk_vaddr (lk_vaddr),
      .ring_ids (ring_ids),
      .hit      (hit_vec[w]),
      .ring     (way_ring[w]),
      .paddr    (way_paddr[w]),
      .attr     (way_attr[w])
    );
  end

  logic [CNT_W-1:0]  hit_cnt;
  logic [RING_W-1:0] sel_ring;
  logic [VA_W-1:0]   sel_paddr;
  logic [3:0]        sel_attr;

  always_comb begin
    hit_cnt   = '0;
    sel_ring  = '0;
    sel_paddr = '0;
    sel_attr  = '0;
    for (int w = 0; w < N_WAYS; w++) begin
      hit_cnt = hit_cnt + CNT_W'(hit_vec[w]);
      if (hit_vec[w]) begin
        sel_ring  = sel_ring  | way_ring[w];
        sel_paddr = sel_paddr | way_paddr[w];
        sel_attr  = sel_attr  | way_attr[w];
      end
    end
  end

  perm_t raw_perm, eff_perm;
  tlbx_attr_decode u_attr (.attr(sel_attr), .perm(raw_perm));

  logic is_fetch, granted;
  always_comb begin
    is_fetch = (lk_kind == ACC_FETCH);
    eff_perm = raw_perm;
    if (is_fetch) begin
      eff_perm.rd = 1'b0;
      eff_perm.wr = 1'b0;
    end else begin
      eff_perm.ex = 1'b0;
    end
    case (lk_kind)
      ACC_LOAD:  granted = eff_perm.rd;
      ACC_STORE: granted = eff_perm.wr;
      ACC_FETCH: granted = eff_perm.ex;
      default:   granted = 1'b0;
    endcase
  end

  // Next-state of the result stage
  logic              nx_ok;
  logic [4:0]        nx_cause;
  logic [VA_W-1:0]   nx_paddr;
  perm_t             nx_perm;
  logic [RING_W-1:0] nx_ring;

  always_comb begin
    nx_ok    = 1'b0;
    nx_cause = '0;
    nx_paddr = '0;
    nx_perm  = '0;
    nx_ring  = '0;
    if (hit_cnt == '0) begin
      nx_cause = is_fetch ? C_I_MISS : C_D_MISS;
    end else if (hit_cnt > CNT_W'(1)) begin
      nx_cause = is_fetch ? C_I_MULTI : C_D_MULTI;
    end else if (sel_ring < lk_priv) begin
      nx_cause = is_fetch ? C_I_PRIV : C_D_PRIV;
    end else if (!granted) begin
      nx_cause = is_fetch ? C_I_DENY : ((lk_kind == ACC_STORE) ? C_ST_DENY : C_LD_DENY);
    end else begin
      nx_ok    = 1'b1;
      nx_paddr = sel_paddr;
      nx_perm  = eff_perm;
      nx_ring  = sel_ring;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_ok    <= 1'b0;
      res_cause <= '0;
      res_paddr <= '0;
      res_read  <= 1'b0;
      res_write <= 1'b0;
      res_exec  <= 1'b0;
      res_cache <= '0;
      res_ring  <= '0;
    end else begin
      res_valid <= lk_valid;
      if (lk_valid) begin
        res_ok    <= nx_ok;
        res_cause <= nx_cause;
        res_paddr <= nx_paddr;
        res_read  <= nx_perm.rd;
        res_write <= nx_perm.wr;
        res_exec  <= nx_perm.ex;
        res_cache <= nx_perm.cm;
        res_ring  <= nx_ring;
      end
    end
  end

  // R3: only a single hit can lead to success
  p_single_hit_needed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && hit_cnt != CNT_W'(1)) |=> (res_valid && !res_ok));
  // R4: a ring below the privilege index never succeeds
  p_low_ring_fails_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && hit_cnt == CNT_W'(1) && sel_ring < lk_priv) |=> !res_ok);
  // R7: data accesses never report execute rights
  p_data_no_exec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_kind != ACC_FETCH) |=> !res_exec);
  // R7: fetches never report read or write rights
  p_fetch_no_rw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_kind == ACC_FETCH) |=> (!res_read && !res_write));
  // R9: result valid follows lookup by one cycle
  p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);
  // R9: a failed result carries no translation
  p_fault_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ok) |-> (res_paddr == '0 && !res_read && !res_write && !res_exec
                               && res_cache == '0 && res_cause != '0));
endmodule

// File: tb/tlbx_lookup_bench.sv
module tlbx_lookup_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_way, wr_idx;
  logic [31:0] wr_vpage, wr_ppage;
  logic [7:0]  wr_asid;
  logic [3:0]  wr_attr;
  logic        lk_valid;
  logic [31:0] lk_vaddr;
  logic [1:0]  lk_kind, lk_priv;
  logic [31:0] ring_ids;
  logic        res_valid, res_ok, res_read, res_write, res_exec;
  logic [4:0]  res_cause;
  logic [31:0] res_paddr;
  logic [2:0]  res_cache;
  logic [1:0]  res_ring;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tlbx_lookup u_tlbx_lookup (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_way(wr_way), .wr_idx(wr_idx),
    .wr_vpage(wr_vpage), .wr_ppage(wr_ppage), .wr_asid(wr_asid), .wr_attr(wr_attr),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind), .lk_priv(lk_priv),
    .ring_ids(ring_ids), .res_valid(res_valid), .res_ok(res_ok), .res_cause(res_cause),
    .res_paddr(res_paddr), .res_read(res_read), .res_write(res_write), .res_exec(res_exec),
    .res_cache(res_cache), .res_ring(res_ring)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic write_entry(logic [1:0] way, logic [1:0] idx, logic [31:0] vp,
                             logic [31:0] pp, logic [7:0] id, logic [3:0] at);
    @(negedge clk);
    wr_en = 1'b1; wr_way = way; wr_idx = idx;
    wr_vpage = vp; wr_ppage = pp; wr_asid = id; wr_attr = at;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Issue one lookup and compare the registered result one cycle later.
  task automatic look(string tag, logic [31:0] va, logic [1:0] kind, logic [1:0] priv,
                      logic ok, logic [4:0] cause, logic [31:0] pa,
                      logic [2:0] rwx, logic [2:0] cm);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_kind = kind; lk_priv = priv;
    @(negedge clk);
    lk_valid = 1'b0;
    check(tag, {21'd0, res_valid, res_ok, res_cause, res_paddr, res_read, res_write, res_exec, res_cache},
               {21'd0, 1'b1, ok, cause, pa, rwx, cm});
  endtask

  localparam logic [31:0] VA0 = 32'h0000_3ABC;

  task automatic t_reset_r9;
    check("R9 reset res_valid", {63'd0, res_valid}, 64'd0);
    look("R9 R3 load miss after reset", VA0, 2'd0, 2'd0, 1'b0, 5'd24, 32'd0, 3'b000, 3'd0);
    @(negedge clk);
    check("R9 res_valid drops", {63'd0, res_valid}, 64'd0);
    look("R3 fetch miss after reset", VA0, 2'd2, 2'd0, 1'b0, 5'd16, 32'd0, 3'b000, 3'd0);
  endtask

  task automatic t_basic_r10;
    write_entry(2'd0, 2'd3, 32'h0000_3FFF, 32'h1234_5FFF, 8'h01, 4'h7);
    look("R10 R8 load hit way0", VA0, 2'd0, 2'd0, 1'b1, 5'd0, 32'h1234_5ABC, 3'b110, 3'd2);
    check("R1 ring 0", {62'd0, res_ring}, 64'd0);
    look("R7 fetch hit way0", VA0, 2'd2, 2'd0, 1'b1, 5'd0, 32'h1234_5ABC, 3'b001, 3'd2);
    look("R2 page mismatch", 32'h1000_3ABC, 2'd0, 2'd0, 1'b0, 5'd24, 32'd0, 3'b000, 3'd0);
  endtask

  task automatic t_priv_r4;
    look("R4 data privilege", VA0, 2'd0, 2'd1, 1'b0, 5'd26, 32'd0, 3'b000, 3'd0);
    look("R4 fetch privilege", VA0, 2'd2, 2'd1, 1'b0, 5'd18, 32'd0, 3'b000, 3'd0);
  endtask

  task automatic t_rings_r1;
    ring_ids = 32'h0101_0000;
    look("R1 lowest lane ok", VA0, 2'd1, 2'd2, 1'b1, 5'd0, 32'h1234_5ABC, 3'b110, 3'd2);
    check("R1 ring 2", {62'd0, res_ring}, 64'd2);
    look("R1 R4 ring2 priv3", VA0, 2'd0, 2'd3, 1'b0, 5'd26, 32'd0, 3'b000, 3'd0);
    ring_ids = 32'h0506_0708;
    look("R1 id absent", VA0, 2'd0, 2'd0, 1'b0, 5'd24, 32'd0, 3'b000, 3'd0);
    ring_ids = 32'h0403_0201;
  endtask

  task automatic t_multi_r3;
    write_entry(2'd1, 2'd0, 32'h0000_0000, 32'h0000_0000, 8'h01, 4'h7);
    look("R3 data multi-hit", VA0, 2'd0, 2'd0, 1'b0, 5'd25, 32'd0, 3'b000, 3'd0);
    look("R3 fetch multi-hit", VA0, 2'd2, 2'd0, 1'b0, 5'd17, 32'd0, 3'b000, 3'd0);
    write_entry(2'd1, 2'd0, 32'h0000_0000, 32'h0000_0000, 8'h09, 4'h7);
    look("R1 unmapped id not a hit", VA0, 2'd0, 2'd0, 1'b1, 5'd0, 32'h1234_5ABC, 3'b110, 3'd2);
    write_entry(2'd1, 2'd0, 32'h0000_0000, 32'h0000_0000, 8'h00, 4'h7);
    look("R10 id0 invalidates", VA0, 2'd0, 2'd0, 1'b1, 5'd0, 32'h1234_5ABC, 3'b110, 3'd2);
  endtask

  task automatic t_attr_r5_r6;
    write_entry(2'd0, 2'd3, 32'h0000_3000, 32'h1234_5000, 8'h01, 4'h0);
    look("R5 attr0 load bypass", VA0, 2'd0, 2'd0, 1'b1, 5'd0, 32'h1234_5ABC, 3'b100, 3'd1);
    look("R7 attr0 store denied", VA0, 2'd1, 2'd0, 1'b0, 5'd29, 32'd0, 3'b000, 3'd0);
    write_entry(2'd0, 2'd3, 32'h0000_3000, 32'h1234_5000, 8'h01, 4'h2);
    look("R5 attr2 store", VA0, 2'd1, 2'd0, 1'b1, 5'd0, 32'h1234_5ABC, 3'b110, 3'd1);
    write_entry(2'd0, 2'd3, 32'h0000_3000, 32'h1234_5000, 8'h01, 4'h8);
    look("R5 attr8 write-through", VA0, 2'd0, 2'd0, 1'b1, 5'd0, 32'h1234_5ABC, 3'b100, 3'd3);
    write_entry(2'd0, 2'd3, 32'h0000_3000, 32'h1234_5000, 8'h01, 4'h5);
    look("R5 attr5 fetch", VA0, 2'd2, 2'd0, 1'b1, 5'd0, 32'h1234_5ABC, 3'b001, 3'd2);
    write_entry(2'd0, 2'd3, 32'h0000_3000, 32'h1234_5000, 8'h01, 4'h6);
    look("R7 attr6 fetch denied", VA0, 2'd2, 2'd0, 1'b0, 5'd20, 32'd0, 3'b000, 3'd0);
    write_entry(2'd0, 2'd3, 32'h0000_3000, 32'h1234_5000, 8'h01, 4'hD);
    look("R6 attr13 store isolate", VA0, 2'd1, 2'd0, 1'b1, 5'd0, 32'h1234_5ABC, 3'b110, 3'd4);
    look("R6 attr13 fetch denied", VA0, 2'd2, 2'd0, 1'b0, 5'd20, 32'd0, 3'b000, 3'd0);
    write_entry(2'd0, 2'd3, 32'h0000_3000, 32'h1234_5000, 8'h01, 4'hC);
    look("R6 attr12 load denied", VA0, 2'd0, 2'd0, 1'b0, 5'd28, 32'd0, 3'b000, 3'd0);
    write_entry(2'd0, 2'd3, 32'h0000_3000, 32'h1234_5000, 8'h01, 4'hF);
    look("R6 attr15 load denied", VA0, 2'd0, 2'd0, 1'b0, 5'd28, 32'd0, 3'b000, 3'd0);
  endtask

  task automatic t_paddr_r8;
    write_entry(2'd3, 2'd3, 32'hABCF_FFFF, 32'h5557_FFFF, 8'h02, 4'h4);
    look("R8 way3 large page", 32'hABCD_1234, 2'd0, 2'd0, 1'b1, 5'd0, 32'h5555_1234, 3'b100, 3'd2);
    check("R1 way3 ring 1", {62'd0, res_ring}, 64'd1);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_way = '0; wr_idx = '0; wr_vpage = '0; wr_ppage = '0;
    wr_asid = '0; wr_attr = '0; lk_valid = 1'b0; lk_vaddr = '0; lk_kind = '0; lk_priv = '0;
    ring_ids = 32'h0403_0201;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r9();
    t_basic_r10();
    t_priv_r4();
    t_rings_r1();
    t_multi_r3();
    t_attr_r5_r6();
    t_paddr_r8();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule